// File: doc/BRIEF.md
# Daisy-Chained Bus Ownership Arbiter

This block decides which of several devices on a shared bus may drive it. Each device sits at a fixed position on a serial grant chain. When any device raises a request, a central arbiter drives a grant onto the head of the chain. The grant ripples through the positions in order. The first position holding a pending request keeps the grant and does not pass it on. That device then takes the bus in four steps. It raises select-acknowledge and drops its request. The arbiter withdraws the grant. The device then raises bus-busy and drops select-acknowledge. It holds bus-busy until its transfer is done.

A terminator sits after the last position. It acknowledges any grant that reaches the end of the chain, so a grant nobody claims cannot hang the arbiter. The same terminator also reads an open chain position (one configured not to pass grants) as a grant. It then acknowledges forever, and the arbiter waits for a grant it never issued. The block reports that condition on a stall output.

A bus-initialize input clears device state without any acknowledge. It takes effect when initialize is released, and it never cuts short a bus-busy tenure already in progress. Every signal is active-high and synchronous to one clock. Each handshake phase takes at least one cycle.

Top module: `bus_chain_arbiter`

## Requirements
- R1: A one-cycle pulse on `req_i[i]` (bus idle, no acknowledge present) follows a fixed timing, counted in clock edges after the pulse is sampled. `req_pend_o[i]` rises after 1 edge and `grant_o` after 2. After 3 edges `dev_ack_o[i]` rises and `req_pend_o[i]` falls. `grant_o` falls after 4. After 5 edges `busy_o[i]` and `bbsy_o` rise and `dev_ack_o[i]` falls.
- R2: A device keeps `busy_o[i]` high until `done_i[i]` is sampled high, and drops it on that same edge.
- R3: When several devices are pending, the grant goes to the one with the lowest index, which is nearest the arbiter. Devices with higher indices see no grant until a later grant cycle.
- R4: Once raised, `grant_o` stays high until the arbiter samples select-acknowledge from some source. There is no timeout.
- R5: A grant that no position claims reaches the terminator. `term_ack_o` rises one edge after the grant reaches the end of the chain. `grant_o` falls on the next edge, and `term_ack_o` falls one edge after that. No device becomes busy.
- R6: While `cut_i[i]` is high, every position after i and the terminator see a grant. `term_ack_o` then stays high, `grant_o` is never raised even with requests pending, and `stall_o` is high from the second cycle of acknowledge without a grant. Clearing `cut_i` lets the arbiter resume.
- R7: At most one bit of `busy_o` is high at any time, and at most one acknowledge source (the devices or the terminator) is high at any time. Each grant ends on exactly one source.
- R8: While `bus_init_i` is high, new requests are ignored. A `busy_o` tenure in progress continues through initialize and after it, until `done_i`. A pending request is cleared when `bus_init_i` falls, and that device is not granted later.
- R9: The arbiter raises a new grant only when `sack_o` and `bbsy_o` are both low. There is no grant while any device is busy.
- R10: A device whose request is registered while the grant is already high at its position passes that grant on. It claims only on a later grant cycle, so a farther device that already claimed owns the bus first.
- R11: `cancel_i[i]` withdraws a pending request. The device then neither acknowledges nor becomes busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_init_i | input | 1 | Bus initialize; devices reset when it is released |
| req_i | input | N_DEV | Request pulse per device |
| cancel_i | input | N_DEV | Withdraw a pending request |
| done_i | input | N_DEV | End the bus-busy tenure |
| cut_i | input | N_DEV | Position does not pass the grant (open chain) |
| grant_o | output | 1 | Grant driven by the arbiter into the chain head |
| sack_o | output | 1 | Combined select-acknowledge |
| bbsy_o | output | 1 | Combined bus-busy |
| req_pend_o | output | N_DEV | Request line per device |
| dev_ack_o | output | N_DEV | Select-acknowledge per device |
| busy_o | output | N_DEV | Bus-busy per device |
| term_ack_o | output | 1 | Select-acknowledge from the terminator |
| stall_o | output | 1 | Acknowledge held with no grant issued |

## Verification
Suppose a device keeps or passes the grant wrongly. Within one edge of the grant, the acknowledge then comes from the wrong position or from the terminator, and the owner order kept by the scoreboard breaks when the next bus-busy appears. A lost phase shows at once: `grant_o` falls too early or too late, or no owner appears within a bounded window. A bad initialize shows the bus-busy tenure cut short, or a pending request that survives the release of initialize and wins a later grant. A stall detector that is wrong shows as a grant issued during an open chain, or as `stall_o` staying low.

// File: rtl/arb_chain_pkg.sv
package arb_chain_pkg;
  typedef enum logic [1:0] {
    NODE_IDLE,
    NODE_PEND,
    NODE_ACK,
    NODE_BUSY
  } node_st_e;

  typedef enum logic {
    ARB_IDLE,
    ARB_GRANT
  } arb_st_e;
endpackage

// File: rtl/chain_arbiter.sv
module chain_arbiter
  import arb_chain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sack_i,
  input  logic bbsy_i,
  output logic grant_o,
  output logic stall_o
);
  arb_st_e st_q, st_d;
  logic    orphan_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ARB_IDLE:  if (req_i && !sack_i && !bbsy_i) st_d = ARB_GRANT;
      ARB_GRANT: if (sack_i) st_d = ARB_IDLE;
      default:   st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ARB_IDLE;
      orphan_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      orphan_q <= (st_q == ARB_IDLE) && sack_i;
    end
  end

  assign grant_o = (st_q == ARB_GRANT);
  // a legal acknowledge overlaps the idle state for one cycle only
  assign stall_o = orphan_q && (st_q == ARB_IDLE) && sack_i;

  p_grant_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o && !sack_i |=> grant_o);

  p_grant_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(!sack_i && !bbsy_i && req_i));
endmodule

// File: rtl/chain_node.sv
module chain_node
  import arb_chain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic req_i,
  input  logic cancel_i,
  input  logic done_i,
  input  logic cut_i,
  input  logic grant_i,
  output logic grant_o,
  output logic req_o,
  output logic ack_o,
  output logic busy_o
);
  node_st_e st_q, st_d;
  logic     grant_q;
  logic     rst_pend_q, rst_pend_d;
  logic     claim, hold;

  // claim only a grant that arrives while already pending
  assign claim = (st_q == NODE_PEND) && grant_i && !grant_q;
  assign hold  = claim || (st_q == NODE_ACK);
  // an open position reads as an asserted grant downstream
  assign grant_o = cut_i | (grant_i & ~hold);

  always_comb begin
    st_d = st_q;
    case (st_q)
      NODE_IDLE: if (req_i && !init_i && !rst_pend_q) st_d = NODE_PEND;
      NODE_PEND: begin
        if (claim)         st_d = NODE_ACK;
        else if (cancel_i) st_d = NODE_IDLE;
      end
      NODE_ACK:  if (!grant_i) st_d = NODE_BUSY;
      NODE_BUSY: if (done_i)   st_d = NODE_IDLE;
      default:   st_d = NODE_IDLE;
    endcase
    if (!init_i && rst_pend_q && st_q != NODE_BUSY) st_d = NODE_IDLE;
    rst_pend_d = init_i | (rst_pend_q & (st_q == NODE_BUSY));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= NODE_IDLE;
      grant_q    <= 1'b0;
      rst_pend_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      grant_q    <= grant_i;
      rst_pend_q <= rst_pend_d;
    end
  end

  assign req_o  = (st_q == NODE_PEND);
  assign ack_o  = (st_q == NODE_ACK);
  assign busy_o = (st_q == NODE_BUSY);

  p_ack_needs_grant_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(grant_i));

  p_busy_after_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ack_o) && !ack_o);

  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o);
endmodule

// File: rtl/chain_term.sv
module chain_term (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= grant_i;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/bus_chain_arbiter.sv
module bus_chain_arbiter
  import arb_chain_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_init_i,
  input  logic [N_DEV-1:0] req_i,
  input  logic [N_DEV-1:0] cancel_i,
  input  logic [N_DEV-1:0] done_i,
  input  logic [N_DEV-1:0] cut_i,
  output logic             grant_o,
  output logic             sack_o,
  output logic             bbsy_o,
  output logic [N_DEV-1:0] req_pend_o,
  output logic [N_DEV-1:0] dev_ack_o,
  output logic [N_DEV-1:0] busy_o,
  output logic             term_ack_o,
  output logic             stall_o
);
  localparam int N_SRC = N_DEV + 1;

  logic [N_DEV:0]   gchain;
  logic [N_SRC-1:0] ack_src;
  logic             arb_grant;

  chain_arbiter i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (|req_pend_o),
    .sack_i  (sack_o),
    .bbsy_i  (bbsy_o),
    .grant_o (arb_grant),
    .stall_o (stall_o)
  );

  assign gchain[0] = arb_grant;

  for (genvar i = 0; i < N_DEV; i++) begin : g_node
    chain_node i_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .init_i   (bus_init_i),
      .req_i    (req_i[i]),
      .cancel_i (cancel_i[i]),
      .done_i   (done_i[i]),
      .cut_i    (cut_i[i]),
      .grant_i  (gchain[i]),
      .grant_o  (gchain[i+1]),
      .req_o    (req_pend_o[i]),
      .ack_o    (dev_ack_o[i]),
      .busy_o   (busy_o[i])
    );
  end

  chain_term i_term (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_i (gchain[N_DEV]),
    .ack_o   (term_ack_o)
  );

  assign ack_src = {term_ack_o, dev_ack_o};
  assign sack_o  = |ack_src;
  assign bbsy_o  = |busy_o;
  assign grant_o = arb_grant;

  p_one_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_o));

  p_single_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_o) |-> ($countones($past(ack_src)) == 1));
endmodule

// File: tb/test_bus_chain_arbiter.sv
module test_bus_chain_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni, bus_init_i;
  logic [N-1:0] req_i, cancel_i, done_i, cut_i;
  logic         grant_o, sack_o, bbsy_o, term_ack_o, stall_o;
  logic [N-1:0] req_pend_o, dev_ack_o, busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  logic fin = 1'b0;
  logic multi_busy = 1'b0;
  logic multi_ack = 1'b0;
  logic [N-1:0] busy_prev = '0;

  always #4 clk = ~clk;

  bus_chain_arbiter #(.N_DEV(N)) i_bus_chain_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .bus_init_i(bus_init_i),
    .req_i(req_i), .cancel_i(cancel_i), .done_i(done_i), .cut_i(cut_i),
    .grant_o(grant_o), .sack_o(sack_o), .bbsy_o(bbsy_o),
    .req_pend_o(req_pend_o), .dev_ack_o(dev_ack_o), .busy_o(busy_o),
    .term_ack_o(term_ack_o), .stall_o(stall_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // scoreboard monitor: each new owner must match the queued order
  always @(negedge clk) begin
    if (rst_ni) begin
      if ($countones(busy_o) > 1) multi_busy <= 1'b1;
      if ($countones({term_ack_o, dev_ack_o}) > 1) multi_ack <= 1'b1;
      for (int i = 0; i < N; i++) begin
        if (busy_o[i] && !busy_prev[i]) begin
          if (exp_q.size() == 0) chk("R3 unexpected owner", i, 32'hffff);
          else chk("R3 owner order", i, exp_q.pop_front());
        end
      end
      busy_prev <= busy_o;
    end
  end

  task automatic wait_busy(input int idx);
    logic seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      tick();
      if (busy_o[idx]) seen = 1'b1;
    end
    chk("R1 owner reached", seen, 1);
  endtask

  task automatic release_dev(input int idx);
    done_i[idx] = 1'b1;
    tick();
    done_i[idx] = 1'b0;
    chk("R2 busy drops on done", busy_o[idx], 0);
  endtask

  task automatic pulse_req(input int idx);
    req_i[idx] = 1'b1;
    tick();
    req_i[idx] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; bus_init_i = 1'b0;
    req_i = '0; cancel_i = '0; done_i = '0; cut_i = '0;
    repeat (3) tick();
    chk("R1 reset grant", grant_o, 0);
    chk("R1 reset sack", sack_o, 0);
    chk("R1 reset bbsy", bbsy_o, 0);
    chk("R6 reset stall", stall_o, 0);
    rst_ni = 1'b1;
    tick();

    // R1 / R2 / R4: single device handshake timing
    exp_q.push_back(1);
    pulse_req(1);
    chk("R1 req line", req_pend_o[1], 1);
    chk("R1 no grant yet", grant_o, 0);
    tick();
    chk("R1 grant up", grant_o, 1);
    chk("R1 no ack yet", dev_ack_o[1], 0);
    tick();
    chk("R1 ack up", dev_ack_o[1], 1);
    chk("R1 req dropped", req_pend_o[1], 0);
    chk("R4 grant held until ack seen", grant_o, 1);
    tick();
    chk("R1 grant dropped", grant_o, 0);
    chk("R1 ack still up", dev_ack_o[1], 1);
    chk("R1 not busy yet", busy_o[1], 0);
    tick();
    chk("R1 busy up", busy_o[1], 1);
    chk("R1 bbsy up", bbsy_o, 1);
    chk("R1 ack dropped", dev_ack_o[1], 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 busy held", busy_o[1], 1);
    end
    release_dev(1);

    // R3 / R9: two pending, nearest wins; no grant while busy
    exp_q.push_back(2);
    exp_q.push_back(3);
    req_i[2] = 1'b1; req_i[3] = 1'b1;
    tick();
    req_i = '0;
    wait_busy(2);
    chk("R3 far device waits", busy_o[3], 0);
    chk("R3 far device still pending", req_pend_o[3], 1);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R9 no grant while busy", grant_o, 0);
    end
    release_dev(2);
    wait_busy(3);
    release_dev(3);

    // R10: late request while grant already passing
    exp_q.push_back(3);
    exp_q.push_back(1);
    pulse_req(3);
    tick();
    req_i[1] = 1'b1;
    tick();
    req_i[1] = 1'b0;
    chk("R10 far device claimed", dev_ack_o[3], 1);
    chk("R10 late device pending", req_pend_o[1], 1);
    tick();
    chk("R10 late device no ack", dev_ack_o[1], 0);
    wait_busy(3);
    release_dev(3);
    wait_busy(1);
    release_dev(1);

    // R11 / R5: cancelled request leaves grant unclaimed
    req_i[0] = 1'b1;
    tick();
    req_i[0] = 1'b0; cancel_i[0] = 1'b1;
    tick();
    cancel_i[0] = 1'b0;
    chk("R11 request withdrawn", req_pend_o[0], 0);
    chk("R5 grant issued", grant_o, 1);
    chk("R5 terminator not yet", term_ack_o, 0);
    tick();
    chk("R5 terminator ack", term_ack_o, 1);
    chk("R5 grant still up", grant_o, 1);
    tick();
    chk("R5 grant dropped", grant_o, 0);
    chk("R5 terminator held", term_ack_o, 1);
    tick();
    chk("R5 terminator released", term_ack_o, 0);
    chk("R11 no owner", busy_o, 0);

    // R6: open chain position
    cut_i[3] = 1'b1;
    tick();
    chk("R6 terminator sees phantom grant", term_ack_o, 1);
    pulse_req(0);
    for (int k = 0; k < 12; k++) begin
      tick();
      chk("R6 arbiter never grants", grant_o, 0);
    end
    chk("R6 stall flagged", stall_o, 1);
    chk("R6 device not busy", busy_o[0], 0);
    exp_q.push_back(0);
    cut_i[3] = 1'b0;
    tick();
    chk("R6 terminator clears", term_ack_o, 0);
    chk("R6 stall clears", stall_o, 0);
    wait_busy(0);
    release_dev(0);

    // R8: initialize
    exp_q.push_back(0);
    pulse_req(0);
    wait_busy(0);
    pulse_req(2);
    chk("R8 pending before init", req_pend_o[2], 1);
    bus_init_i = 1'b1;
    req_i[1] = 1'b1;
    tick();
    req_i[1] = 1'b0;
    chk("R8 request ignored in init", req_pend_o[1], 0);
    chk("R8 busy survives init", busy_o[0], 1);
    tick();
    chk("R8 pending held during init", req_pend_o[2], 1);
    bus_init_i = 1'b0;
    tick();
    chk("R8 pending cleared on release", req_pend_o[2], 0);
    chk("R8 busy survives release", busy_o[0], 1);
    tick();
    chk("R8 busy until done", busy_o[0], 1);
    release_dev(0);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R8 cleared device not granted", grant_o, 0);
    end
    chk("R8 nobody busy", busy_o, 0);
    exp_q.push_back(1);
    pulse_req(1);
    wait_busy(1);
    release_dev(1);

    repeat (3) tick();
    chk("R7 single owner", multi_busy, 0);
    chk("R7 single ack source", multi_ack, 0);
    chk("R3 all owners seen", exp_q.size(), 0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule